// File: doc/BRIEF.md
# Bridge Parity Error Reporting Unit

This unit sits beside the data path of a two-sided bus bridge. For each completed data phase it decides whether a parity error happened and how to report it. The error may be a mismatch seen on the initiator bus, or a report passed back from the target bus. The unit drives an active-low PERR# strobe on the primary or secondary side. It keeps a sticky detected-error flag for each side, and it tells the delayed-transaction queue whether to return write status or keep the entry. For posted writes that arrive with bad parity, it flags that the regenerated parity bit on the outgoing bus must be inverted.

A data phase is presented with `dp_valid` together with the address/data word, the byte-enable bits, the direction, the transaction kind and the target-side error flag. The parity bit for that phase follows one clock later. All verdicts for the phase appear as single-cycle outputs on the second rising edge after the data phase. Back-to-back phases flow through a two-stage pipeline, so no report is lost.

Top module: `pe_report_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both PERR# outputs are high and `det_pri`, `det_sec`, `dq_hold`, `dq_ret` and `fwd_bad_par` are 0.
- R2: Parity is even over the 32 `dp_ad` bits plus the 4 `dp_cbe_n` bits. The expected `par_in`, sampled one clock after the data phase, is the XOR of those 36 bits. A difference is an error detected on the initiator bus.
- R3: Every verdict for a data phase sampled at rising edge N appears from edge N+2. A PERR# strobe stays low for exactly one cycle per erroneous phase and is high in the cycle before.
- R4: The initiator bus is primary when `dp_dir`=0 (downstream) and secondary when `dp_dir`=1 (upstream). A parity error detected on the initiator bus drives that side's PERR# low only when that side's enable is set (`cfg_pri_pere` for primary, `cfg_sec_pere` for secondary). The other side's enable has no effect.
- R5: A parity error detected on the initiator bus sets that side's detected flag whatever the enables are. The flag stays set until a cycle with the matching clear input at 1. If a set and a clear fall on the same edge, the set wins.
- R6: A delayed write (`dp_kind`=0) with a parity error detected on the initiator bus pulses `dq_hold` and does not pulse `dq_ret`.
- R7: A delayed write with no parity error detected on the initiator bus pulses `dq_ret`. This includes phases with an error passed back from the target.
- R8: An error passed back from the target (`dp_tgt_err`=1 with matching parity) drives the initiator side's PERR# low only when both `cfg_pri_pere` and `cfg_sec_pere` are 1. It leaves both detected flags unchanged.
- R9: A posted write (`dp_kind`=1) with a parity error detected on the initiator bus pulses `fwd_bad_par`. Posted writes never pulse `dq_hold` or `dq_ret`.
- R10: Data phases on consecutive cycles each produce their own verdicts on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_valid | input | 1 | A data transfer completes this cycle |
| dp_ad | input | 32 | Address/data word of the phase |
| dp_cbe_n | input | 4 | Byte-enable bits of the phase |
| dp_dir | input | 1 | 0 downstream, 1 upstream |
| dp_kind | input | 1 | 0 delayed write, 1 posted write |
| dp_tgt_err | input | 1 | Target bus reported a parity error for this phase |
| par_in | input | 1 | Parity bit for the previous cycle's phase |
| cfg_pri_pere | input | 1 | Primary parity-error-response enable |
| cfg_sec_pere | input | 1 | Secondary parity-error-response enable |
| clr_pri_det | input | 1 | Write-one clear of the primary detected flag |
| clr_sec_det | input | 1 | Write-one clear of the secondary detected flag |
| perr_pri_n | output | 1 | Primary PERR#, active low |
| perr_sec_n | output | 1 | Secondary PERR#, active low |
| det_pri | output | 1 | Sticky primary detected-parity-error flag |
| det_sec | output | 1 | Sticky secondary detected-parity-error flag |
| dq_hold | output | 1 | Keep the delayed write in the queue, no status |
| dq_ret | output | 1 | Return write status for the delayed write |
| fwd_bad_par | output | 1 | Invert regenerated parity for this phase on the outgoing bus |

## Verification
On every cycle, the assertions check the following:
- a PERR# strobe only ever follows a data phase two edges earlier, and only with its own side's enable on;
- the two strobes never fire together;
- the queue verdicts are exclusive;
- parity forwarding only follows posted writes;
- a detected flag only drops after a clear.

Only the bench's scenarios can show the rest: that the right side is chosen, that the enable pair is required for passed-back errors while only one enable counts for initiator errors, that the parity arithmetic is correct, that a set wins over a clear, and that back-to-back phases keep their order.

// File: rtl/pe_report_pkg.sv
package pe_report_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        KIND_DLY = 1'b0,
        KIND_PST = 1'b1
    } kind_e;

    // One data phase waiting for its parity bit
    typedef struct packed {
        logic  vld;
        logic  par_exp;
        dir_e  dir;
        kind_e kind;
        logic  tgt_err;
    } phase_s;

    // Verdict for one phase
    typedef struct packed {
        logic perr_pri;
        logic perr_sec;
        logic set_pri;
        logic set_sec;
        logic hold;
        logic ret;
        logic fwd;
    } verdict_s;

    typedef struct packed {
        phase_s   ph;
        verdict_s vd;
        logic     det_pri;
        logic     det_sec;
    } state_s;

endpackage

// File: rtl/pe_parity_gen.sv
module pe_parity_gen #(
    parameter int W = 36
) (
    input  logic [W-1:0] bits_i,
    output logic         par_o
);
    // Even parity: the bit that makes the total count of ones even
    always_comb begin
        par_o = ^bits_i;
    end
endmodule

// File: rtl/pe_verdict.sv
module pe_verdict
    import pe_report_pkg::*;
(
    input  phase_s   ph_i,
    input  logic     par_i,
    input  logic     en_pri_i,
    input  logic     en_sec_i,
    output verdict_s vd_o
);
    logic mism;
    logic passed;
    logic init_pri;
    logic en_init;
    logic report;

    always_comb begin
        mism     = ph_i.vld && (ph_i.par_exp != par_i);
        passed   = ph_i.vld && ph_i.tgt_err && !mism;
        init_pri = (ph_i.dir == DIR_DOWN);
        en_init  = init_pri ? en_pri_i : en_sec_i;
        report   = (mism && en_init) || (passed && en_pri_i && en_sec_i);

        vd_o.perr_pri = report && init_pri;
        vd_o.perr_sec = report && !init_pri;
        vd_o.set_pri  = mism && init_pri;
        vd_o.set_sec  = mism && !init_pri;
        vd_o.hold     = mism && (ph_i.kind == KIND_DLY);
        vd_o.ret      = ph_i.vld && !mism && (ph_i.kind == KIND_DLY);
        vd_o.fwd      = mism && (ph_i.kind == KIND_PST);
    end
endmodule

// File: rtl/pe_report_unit.sv
module pe_report_unit
    import pe_report_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dp_valid,
    input  logic [AD_W-1:0] dp_ad,
    input  logic [BE_W-1:0] dp_cbe_n,
    input  logic            dp_dir,
    input  logic            dp_kind,
    input  logic            dp_tgt_err,
    input  logic            par_in,
    input  logic            cfg_pri_pere,
    input  logic            cfg_sec_pere,
    input  logic            clr_pri_det,
    input  logic            clr_sec_det,
    output logic            perr_pri_n,
    output logic            perr_sec_n,
    output logic            det_pri,
    output logic            det_sec,
    output logic            dq_hold,
    output logic            dq_ret,
    output logic            fwd_bad_par
);
    localparam int CHK_W = AD_W + BE_W;

    state_s   st_d;
    state_s   st_q;
    logic     par_calc;
    verdict_s vd_now;

    pe_parity_gen #(.W(CHK_W)) u_par (
        .bits_i ({dp_ad, dp_cbe_n}),
        .par_o  (par_calc)
    );

    pe_verdict u_vd (
        .ph_i     (st_q.ph),
        .par_i    (par_in),
        .en_pri_i (cfg_pri_pere),
        .en_sec_i (cfg_sec_pere),
        .vd_o     (vd_now)
    );

    always_comb begin
        st_d            = st_q;
        // stage 1: remember the phase until its parity bit arrives
        st_d.ph.vld     = dp_valid;
        st_d.ph.par_exp = par_calc;
        st_d.ph.dir     = dir_e'(dp_dir);
        st_d.ph.kind    = kind_e'(dp_kind);
        st_d.ph.tgt_err = dp_tgt_err;
        // stage 2: verdict pulses
        st_d.vd         = vd_now;
        // sticky flags, a set on the same edge beats a clear
        st_d.det_pri    = (st_q.det_pri && !clr_pri_det) || vd_now.set_pri;
        st_d.det_sec    = (st_q.det_sec && !clr_sec_det) || vd_now.set_sec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_pri_n  = ~st_q.vd.perr_pri;
    assign perr_sec_n  = ~st_q.vd.perr_sec;
    assign det_pri     = st_q.det_pri;
    assign det_sec     = st_q.det_sec;
    assign dq_hold     = st_q.vd.hold;
    assign dq_ret      = st_q.vd.ret;
    assign fwd_bad_par = st_q.vd.fwd;

endmodule

// File: rtl/pe_report_chk.sv
module pe_report_chk (
    input logic clk,
    input logic rst_n,
    input logic dp_valid,
    input logic dp_kind,
    input logic cfg_pri_pere,
    input logic cfg_sec_pere,
    input logic clr_pri_det,
    input logic clr_sec_det,
    input logic perr_pri_n,
    input logic perr_sec_n,
    input logic det_pri,
    input logic det_sec,
    input logic dq_hold,
    input logic dq_ret,
    input logic fwd_bad_par
);
    // R3
    perr_pri_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_pri_n |-> $past(dp_valid, 2));
    // R3
    perr_sec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_sec_n |-> $past(dp_valid, 2));
    // R4
    perr_pri_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_pri_n |-> $past(cfg_pri_pere));
    // R4
    perr_sec_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_sec_n |-> $past(cfg_sec_pere));
    // R4
    perr_one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_pri_n || perr_sec_n);
    // R5
    det_pri_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_pri) |-> $past(clr_pri_det));
    // R5
    det_sec_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_sec) |-> $past(clr_sec_det));
    // R6
    dq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dq_hold, dq_ret}));
    // R9
    fwd_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_bad_par |-> ($past(dp_kind, 2) && !dq_hold && !dq_ret));
endmodule

bind pe_report_unit pe_report_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dp_valid     (dp_valid),
    .dp_kind      (dp_kind),
    .cfg_pri_pere (cfg_pri_pere),
    .cfg_sec_pere (cfg_sec_pere),
    .clr_pri_det  (clr_pri_det),
    .clr_sec_det  (clr_sec_det),
    .perr_pri_n   (perr_pri_n),
    .perr_sec_n   (perr_sec_n),
    .det_pri      (det_pri),
    .det_sec      (det_sec),
    .dq_hold      (dq_hold),
    .dq_ret       (dq_ret),
    .fwd_bad_par  (fwd_bad_par)
);

// File: tb/sim_pe_report_unit.sv
module sim_pe_report_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dp_valid;
    logic [31:0] dp_ad;
    logic [3:0]  dp_cbe_n;
    logic        dp_dir, dp_kind, dp_tgt_err, par_in;
    logic        cfg_pri_pere, cfg_sec_pere, clr_pri_det, clr_sec_det;
    logic        perr_pri_n, perr_sec_n, det_pri, det_sec;
    logic        dq_hold, dq_ret, fwd_bad_par;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    pe_report_unit u0 (
        .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .dp_ad(dp_ad),
        .dp_cbe_n(dp_cbe_n), .dp_dir(dp_dir), .dp_kind(dp_kind),
        .dp_tgt_err(dp_tgt_err), .par_in(par_in),
        .cfg_pri_pere(cfg_pri_pere), .cfg_sec_pere(cfg_sec_pere),
        .clr_pri_det(clr_pri_det), .clr_sec_det(clr_sec_det),
        .perr_pri_n(perr_pri_n), .perr_sec_n(perr_sec_n),
        .det_pri(det_pri), .det_sec(det_sec), .dq_hold(dq_hold),
        .dq_ret(dq_ret), .fwd_bad_par(fwd_bad_par)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_outputs(input string tag);
        chk({tag, " perr_pri_n"}, perr_pri_n, 1'b1);
        chk({tag, " perr_sec_n"}, perr_sec_n, 1'b1);
        chk({tag, " dq_hold"}, dq_hold, 1'b0);
        chk({tag, " dq_ret"}, dq_ret, 1'b0);
        chk({tag, " fwd"}, fwd_bad_par, 1'b0);
    endtask

    task automatic drive_phase(input logic dir, input logic kind, input logic tgt,
                               input logic [31:0] ad, input logic [3:0] be);
        dp_valid   = 1'b1;
        dp_dir     = dir;
        dp_kind    = kind;
        dp_tgt_err = tgt;
        dp_ad      = ad;
        dp_cbe_n   = be;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; dp_valid = 0; dp_ad = '0; dp_cbe_n = '0; dp_dir = 0;
        dp_kind = 0; dp_tgt_err = 0; par_in = 0; cfg_pri_pere = 0;
        cfg_sec_pere = 0; clr_pri_det = 0; clr_sec_det = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        idle_outputs("R1 in reset");
        chk("R1 det_pri", det_pri, 1'b0);
        chk("R1 det_sec", det_sec, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_outputs("R1 after reset");

        // sweep: dir x kind x origin(none/init/target/both) x enables
        for (int c = 0; c < 64; c++) begin
            automatic logic        dir  = c[0];
            automatic logic        kind = c[1];
            automatic logic        mm   = c[2];
            automatic logic        tgt  = c[3];
            automatic logic        pe   = c[4];
            automatic logic        se   = c[5];
            automatic logic [31:0] ad   = (c * 32'h9E3779B1) ^ 32'h5A5A0F0F;
            automatic logic [3:0]  be   = 4'(c) ^ 4'hA;
            automatic logic        gp   = ^{ad, be};
            automatic logic        passed = tgt && !mm;
            automatic logic        en_i = dir ? se : pe;
            automatic logic        rep  = (mm && en_i) || (passed && pe && se);
            automatic string       ptag = mm ? "R4" : "R8";
            cfg_pri_pere = pe;
            cfg_sec_pere = se;
            drive_phase(dir, kind, tgt, ad, be);
            @(negedge clk);
            dp_valid = 0; dp_tgt_err = 0;
            par_in = gp ^ mm;
            // R3: nothing yet one cycle after the data phase
            chk("R3 early perr_pri_n", perr_pri_n, 1'b1);
            chk("R3 early perr_sec_n", perr_sec_n, 1'b1);
            @(negedge clk);
            chk({ptag, " perr_pri_n"}, perr_pri_n, !(rep && !dir));
            chk({ptag, " perr_sec_n"}, perr_sec_n, !(rep && dir));
            chk("R2 det_pri", det_pri, mm && !dir);
            chk("R2 det_sec", det_sec, mm && dir);
            chk("R6 dq_hold", dq_hold, mm && !kind);
            chk("R7 dq_ret", dq_ret, !mm && !kind);
            chk("R9 fwd_bad_par", fwd_bad_par, mm && kind);
            clr_pri_det = 1; clr_sec_det = 1; par_in = 0;
            @(negedge clk);
            clr_pri_det = 0; clr_sec_det = 0;
            idle_outputs("R3 one cycle");
            chk("R5 cleared det_pri", det_pri, 1'b0);
            chk("R5 cleared det_sec", det_sec, 1'b0);
        end

        // R5: set wins over clear, flag set with enables off, flag sticky
        begin
            automatic logic [31:0] ad = 32'hCAFE0123;
            automatic logic [3:0]  be = 4'h3;
            cfg_pri_pere = 0; cfg_sec_pere = 0;
            drive_phase(1'b0, 1'b1, 1'b0, ad, be);
            @(negedge clk);
            dp_valid = 0;
            par_in = ~(^{ad, be});
            clr_pri_det = 1;
            @(negedge clk);
            clr_pri_det = 0;
            chk("R5 set beats clear", det_pri, 1'b1);
            chk("R4 enable off no perr", perr_pri_n, 1'b1);
            chk("R9 posted forward", fwd_bad_par, 1'b1);
            repeat (3) @(negedge clk);
            chk("R5 sticky", det_pri, 1'b1);
            chk("R5 other side untouched", det_sec, 1'b0);
            clr_pri_det = 1;
            @(negedge clk);
            clr_pri_det = 0;
            chk("R5 write-one clear", det_pri, 1'b0);
        end

        // R10: back-to-back phases
        begin
            automatic logic [31:0] a1 = 32'h12345678;
            automatic logic [31:0] a2 = 32'h0F0F00FF;
            automatic logic [3:0]  b1 = 4'h1;
            automatic logic [3:0]  b2 = 4'h7;
            cfg_pri_pere = 1; cfg_sec_pere = 1;
            drive_phase(1'b0, 1'b0, 1'b0, a1, b1);
            @(negedge clk);
            par_in = ~(^{a1, b1});
            drive_phase(1'b1, 1'b1, 1'b0, a2, b2);
            @(negedge clk);
            dp_valid = 0;
            par_in = ~(^{a2, b2});
            chk("R10 first perr_pri_n", perr_pri_n, 1'b0);
            chk("R10 first perr_sec_n", perr_sec_n, 1'b1);
            chk("R10 first dq_hold", dq_hold, 1'b1);
            chk("R10 first fwd", fwd_bad_par, 1'b0);
            @(negedge clk);
            par_in = 0;
            chk("R10 second perr_pri_n", perr_pri_n, 1'b1);
            chk("R10 second perr_sec_n", perr_sec_n, 1'b0);
            chk("R10 second dq_hold", dq_hold, 1'b0);
            chk("R10 second fwd", fwd_bad_par, 1'b1);
            chk("R10 both flags pri", det_pri, 1'b1);
            chk("R10 both flags sec", det_sec, 1'b1);
            @(negedge clk);
            idle_outputs("R10 drained");
        end

        finish_run();
    end
endmodule